// File: doc/BRIEF.md
# Five-Level Phase Gate Selector with Floating-Capacitor Balancing

This block turns a requested output level for one phase of a five-level hybrid inverter into six registered gate commands. The phase is a two-level leg (two gates) in series with a floating-capacitor H-bridge cell (four gates). Levels +2 and −2 each have one switch combination. Level 0 has two, and these move the capacitor charge in opposite directions. The block picks between them from the load current polarity and a hysteresis decision on the digitized capacitor voltage. No capacitor current measurement is needed.

A voltage below the band (reference minus half-band) sets the intent to charge, and a voltage above the band (reference plus half-band) sets it to discharge. Inside the band the intent stays as it was. The intent logic is a two-state machine, `INT_CHARGE` and `INT_DISCHARGE`. Transition `T_LOW` moves to charge when the sample is below the band, `T_HIGH` moves to discharge when it is above, and `T_HOLD` keeps the state. The zero-level choice is a second state register with states `ZS_SUB` (leg high, capacitor subtracted) and `ZS_ADD` (leg low, capacitor added). It is re-chosen (`T_PICK`) only when the level code changes or the intent flips. Otherwise it holds (`T_KEEP`).

Besides the gates, the block reports whether the capacitor is in the current path and whether the applied state charges it.

Top module: `phase_gate_sel`

## Requirements
- R1: Level code 3'b010 (+2) drives gates S1..S6 = 0,1,1,0,1,0, and code 3'b110 (−2) drives 1,0,0,1,0,1. Gate Si appears on `gates[i-1]`. The outputs change one clock after the code is sampled.
- R2: Code 3'b001 (+1) drives 1,1,0,0,1,0, and code 3'b111 (−1) drives 0,0,1,1,0,1. The capacitor is bypassed, and both indicator outputs are 0.
- R3: Code 3'b000 (0) with charge intent drives `ZS_ADD` (0,1,1,0,0,1) when `cur_pos`=1 and `ZS_SUB` (1,0,0,1,1,0) when `cur_pos`=0.
- R4: Code 0 with discharge intent drives `ZS_SUB` when `cur_pos`=1 and `ZS_ADD` when `cur_pos`=0.
- R5: A sample strictly below `vref-vhalf` sets charge intent, and a sample strictly above `vref+vhalf` sets discharge intent. A sample within the band, limits included, keeps the intent. A limit outside the range 0..2^VW−1 can never be crossed.
- R6: The zero-level selection is evaluated only when the level code differs from the previous sample or the intent flips. A change of `cur_pos` alone leaves the gates unchanged.
- R7: Codes 3'b011, 3'b100 and 3'b101 are invalid. They drive all gates and both indicators to 0.
- R8: While reset is asserted, all gates and indicators are 0. After reset, the intent is charge and the first sampled code 0 counts as a change.
- R9: `cap_in_path` is 1 for levels +2, −2 and 0. `cap_charging` is 1 when the capacitor is added and `cur_pos`=1, or when it is subtracted and `cur_pos`=0. +2 counts as added and −2 as subtracted. The leg and half-bridge gate pairs (S1/S3, S2/S4, S5/S6) are never both on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_code | input | 3 | Requested level code |
| cur_pos | input | 1 | Load current polarity, 1 = positive |
| vcap | input | VW | Capacitor voltage sample, unsigned |
| vref | input | VW | Regulation reference |
| vhalf | input | VW | Half-width of the hysteresis band |
| gates | output | 6 | Registered gate commands, bit i-1 = Si |
| cap_in_path | output | 1 | Capacitor conducts load current |
| cap_charging | output | 1 | Applied state charges the capacitor |

## Verification
The main sweep pairs every level code and both current polarities with capacitor samples placed below the band, on each band limit, inside it and above it. This separates the four zero-level outcomes and shows that the band limits themselves hold the intent. A second and a third band configuration push one limit out of range, which tells a saturated comparison apart from a wrapped one. Directed sequences flip only the current polarity during a held zero level, which separates re-evaluation on change from re-evaluation on every cycle. They also check the reset value and the first-zero-after-reset behaviour.

// File: rtl/phase_gate_pkg.sv
package phase_gate_pkg;

    typedef logic [2:0] lvl_t;

    localparam lvl_t LVL_ZERO = 3'b000;
    localparam lvl_t LVL_P1   = 3'b001;
    localparam lvl_t LVL_P2   = 3'b010;
    localparam lvl_t LVL_N1   = 3'b111;
    localparam lvl_t LVL_N2   = 3'b110;
    localparam lvl_t LVL_BAD  = 3'b100;

    typedef enum logic {
        INT_DISCHARGE = 1'b0,
        INT_CHARGE    = 1'b1
    } intent_e;

    typedef enum logic {
        ZS_SUB = 1'b0,
        ZS_ADD = 1'b1
    } zsel_e;

    function automatic logic [5:0] pack_gates(input logic s1, input logic s2,
                                              input logic s3, input logic s4,
                                              input logic s5, input logic s6);
        return {s6, s5, s4, s3, s2, s1};
    endfunction

    function automatic logic lvl_valid(input lvl_t l);
        return (l == LVL_ZERO) || (l == LVL_P1) || (l == LVL_P2) ||
               (l == LVL_N1)   || (l == LVL_N2);
    endfunction

endpackage

// File: rtl/cap_hyst.sv
module cap_hyst
    import phase_gate_pkg::*;
#(
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vcap,
    input  logic [VW-1:0] vref,
    input  logic [VW-1:0] vhalf,
    output intent_e       intent_nxt,
    output logic          intent_flip
);
    localparam int SW = VW + 2;

    intent_e              intent_q;
    logic signed [SW-1:0] v_s, lo_s, hi_s;
    logic                 below, above;

    always_comb begin
        v_s   = signed'({2'b00, vcap});
        lo_s  = signed'({2'b00, vref}) - signed'({2'b00, vhalf});
        hi_s  = signed'({2'b00, vref}) + signed'({2'b00, vhalf});
        below = v_s < lo_s;
        above = v_s > hi_s;
    end

    // next-state logic: T_LOW, T_HIGH, T_HOLD
    always_comb begin
        intent_nxt = intent_q;
        unique case (intent_q)
            INT_CHARGE:    if (above) intent_nxt = INT_DISCHARGE;
            INT_DISCHARGE: if (below) intent_nxt = INT_CHARGE;
        endcase
    end

    assign intent_flip = (intent_nxt != intent_q);

    always_ff @(posedge clk) begin
        if (!rst_n) intent_q <= INT_CHARGE;
        else        intent_q <= intent_nxt;
    end

    a_r5_below_sets_charge: assert property (@(posedge clk) disable iff (!rst_n)
        below |=> (intent_q == INT_CHARGE));
    a_r5_above_sets_discharge: assert property (@(posedge clk) disable iff (!rst_n)
        above |=> (intent_q == INT_DISCHARGE));
    a_r5_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!below && !above) |=> $stable(intent_q));

endmodule

// File: rtl/zero_pick.sv
module zero_pick
    import phase_gate_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  lvl_t    level,
    input  logic    cur_pos,
    input  intent_e intent_nxt,
    input  logic    intent_flip,
    output zsel_e   zsel_nxt
);
    lvl_t  prev_q;
    zsel_e zsel_q;
    logic  evt;

    assign evt = (level != prev_q) || intent_flip;

    // T_PICK when in zero level and an event occurs, otherwise T_KEEP
    always_comb begin
        zsel_nxt = zsel_q;
        if ((level == LVL_ZERO) && evt) begin
            unique case (intent_nxt)
                INT_CHARGE:    zsel_nxt = cur_pos ? ZS_ADD : ZS_SUB;
                INT_DISCHARGE: zsel_nxt = cur_pos ? ZS_SUB : ZS_ADD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= LVL_BAD;
            zsel_q <= ZS_SUB;
        end else begin
            prev_q <= level;
            zsel_q <= zsel_nxt;
        end
    end

    a_r6_nonzero_keeps_choice: assert property (@(posedge clk) disable iff (!rst_n)
        (level != LVL_ZERO) |=> $stable(zsel_q));

endmodule

// File: rtl/gate_enc.sv
module gate_enc
    import phase_gate_pkg::*;
#(
    parameter int NG = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lvl_t          level,
    input  logic          cur_pos,
    input  zsel_e         zsel_nxt,
    output logic [NG-1:0] gates,
    output logic          cap_in_path,
    output logic          cap_charging
);
    logic [NG-1:0] g_d;
    logic          path_d, chg_d;

    always_comb begin
        g_d    = '0;
        path_d = 1'b0;
        chg_d  = 1'b0;
        unique case (level)
            LVL_P2: begin
                g_d    = pack_gates(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
                path_d = 1'b1;
                chg_d  = cur_pos;
            end
            LVL_N2: begin
                g_d    = pack_gates(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
                path_d = 1'b1;
                chg_d  = !cur_pos;
            end
            LVL_P1: g_d = pack_gates(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
            LVL_N1: g_d = pack_gates(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
            LVL_ZERO: begin
                path_d = 1'b1;
                unique case (zsel_nxt)
                    ZS_SUB: begin
                        g_d   = pack_gates(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
                        chg_d = !cur_pos;
                    end
                    ZS_ADD: begin
                        g_d   = pack_gates(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
                        chg_d = cur_pos;
                    end
                endcase
            end
            default: begin
                g_d    = '0;
                path_d = 1'b0;
                chg_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gates        <= '0;
            cap_in_path  <= 1'b0;
            cap_charging <= 1'b0;
        end else begin
            gates        <= g_d;
            cap_in_path  <= path_d;
            cap_charging <= chg_d;
        end
    end

    a_r7_invalid_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_valid(level) |=> (gates == '0) && !cap_in_path && !cap_charging);
    a_r9_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates[0] && gates[2]) && !(gates[1] && gates[3]) && !(gates[4] && gates[5]));
    a_r9_charge_needs_path: assert property (@(posedge clk) disable iff (!rst_n)
        cap_charging |-> cap_in_path);
    a_r2_bypass_no_path: assert property (@(posedge clk) disable iff (!rst_n)
        ((level == LVL_P1) || (level == LVL_N1)) |=> !cap_in_path);

endmodule

// File: rtl/phase_gate_sel.sv
module phase_gate_sel
    import phase_gate_pkg::*;
#(
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    level_code,
    input  logic          cur_pos,
    input  logic [VW-1:0] vcap,
    input  logic [VW-1:0] vref,
    input  logic [VW-1:0] vhalf,
    output logic [5:0]    gates,
    output logic          cap_in_path,
    output logic          cap_charging
);
    localparam int NG = 6;

    intent_e intent_nxt;
    logic    intent_flip;
    zsel_e   zsel_nxt;

    cap_hyst #(.VW(VW)) u_hyst (
        .clk         (clk),
        .rst_n       (rst_n),
        .vcap        (vcap),
        .vref        (vref),
        .vhalf       (vhalf),
        .intent_nxt  (intent_nxt),
        .intent_flip (intent_flip)
    );

    zero_pick u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (level_code),
        .cur_pos     (cur_pos),
        .intent_nxt  (intent_nxt),
        .intent_flip (intent_flip),
        .zsel_nxt    (zsel_nxt)
    );

    gate_enc #(.NG(NG)) u_enc (
        .clk          (clk),
        .rst_n        (rst_n),
        .level        (level_code),
        .cur_pos      (cur_pos),
        .zsel_nxt     (zsel_nxt),
        .gates        (gates),
        .cap_in_path  (cap_in_path),
        .cap_charging (cap_charging)
    );

    a_r6_zero_held_gates_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (level_code == LVL_ZERO) && ($past(level_code) == LVL_ZERO)
         && !intent_flip) |=> $stable(gates));
    a_r1_plus2_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code == LVL_P2) |=> (gates == 6'b010110));

endmodule

// File: tb/tb_phase_gate_sel.sv
`timescale 1ns/1ps
module tb_phase_gate_sel;
    localparam int VW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    level_code = 3'b000;
    logic          cur_pos = 1'b0;
    logic [VW-1:0] vcap = '0, vref = '0, vhalf = '0;
    logic [5:0]    gates;
    logic          cap_in_path, cap_charging;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    bit   m_charge;
    bit   m_add;
    logic [2:0] m_prev;

    always #2 clk = ~clk;

    phase_gate_sel #(.VW(VW)) dut (
        .clk(clk), .rst_n(rst_n), .level_code(level_code), .cur_pos(cur_pos),
        .vcap(vcap), .vref(vref), .vhalf(vhalf), .gates(gates),
        .cap_in_path(cap_in_path), .cap_charging(cap_charging)
    );

    function automatic logic [5:0] tup(input int a, b, c, d, e, f);
        return {f[0], e[0], d[0], c[0], b[0], a[0]};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] l, input bit p, input int vc, input string force_tag);
        int lo, hi;
        bit nxt, evt, path, chg, valid;
        logic [5:0] eg;
        string tag;
        @(negedge clk);
        level_code = l; cur_pos = p; vcap = vc[VW-1:0];
        @(posedge clk);
        #1;
        lo = int'(vref) - int'(vhalf);
        hi = int'(vref) + int'(vhalf);
        nxt = m_charge;
        if (vc < lo) nxt = 1;
        else if (vc > hi) nxt = 0;
        evt = (l != m_prev) || (nxt != m_charge);
        if (l == 3'b000 && evt) m_add = (nxt == p);
        m_charge = nxt;
        m_prev = l;
        eg = '0; path = 0; chg = 0; valid = 1;
        case (l)
            3'b010: begin eg = tup(0,1,1,0,1,0); path = 1; chg = p;  tag = "R1"; end
            3'b110: begin eg = tup(1,0,0,1,0,1); path = 1; chg = !p; tag = "R1"; end
            3'b001: begin eg = tup(1,1,0,0,1,0); tag = "R2"; end
            3'b111: begin eg = tup(0,0,1,1,0,1); tag = "R2"; end
            3'b000: begin
                path = 1;
                eg = m_add ? tup(0,1,1,0,0,1) : tup(1,0,0,1,1,0);
                chg = m_add ? p : !p;
                tag = m_charge ? "R3" : "R4";
            end
            default: begin valid = 0; tag = "R7"; end
        endcase
        if (force_tag != "") tag = force_tag;
        chk(tag, {2'b00, gates}, {2'b00, eg});
        chk(valid ? "R9" : "R7", {6'b0, cap_in_path, cap_charging}, {6'b0, path, chg});
    endtask

    task automatic sweep(input int ref_v, input int half_v, input int n, input int seed);
        logic [15:0] lf;
        int vals[7];
        lf = seed[15:0];
        vref = ref_v[VW-1:0]; vhalf = half_v[VW-1:0];
        vals[0] = 0; vals[1] = ref_v - half_v - 1; vals[2] = ref_v - half_v;
        vals[3] = ref_v; vals[4] = ref_v + half_v; vals[5] = ref_v + half_v + 1;
        vals[6] = 4095;
        for (int i = 0; i < n; i++) begin
            int v;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            v = vals[lf[7:4] % 7];
            if (v < 0) v = 0;
            if (v > 4095) v = 4095;
            step(lf[2:0], lf[3], v, "");
        end
    endtask

    initial begin
        m_charge = 1; m_add = 0; m_prev = 3'b100;
        vref = 12'd2048; vhalf = 12'd16;
        level_code = 3'b010; cur_pos = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R8", {gates, cap_in_path, cap_charging}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: first zero after reset with mid-band sample uses charge intent
        step(3'b000, 1, 2048, "R8");
        // R6: only current polarity flips, selection is held
        step(3'b000, 0, 2048, "R6");
        step(3'b000, 1, 2048, "R6");
        // R5: above the band flips intent, re-evaluation follows
        step(3'b000, 1, 2065, "R5");
        step(3'b000, 1, 2064, "R5");
        step(3'b000, 1, 2032, "R5");
        step(3'b000, 0, 2031, "R5");
        // R5: saturated lower limit never crossed
        vref = 12'd10; vhalf = 12'd20;
        step(3'b001, 1, 4095, "R2");
        step(3'b000, 1, 0, "R5");
        // invalid codes
        step(3'b011, 1, 2048, "R7");
        step(3'b100, 0, 2048, "R7");
        step(3'b101, 1, 2048, "R7");
        sweep(2048, 16, 1500, 16'hACE1);
        sweep(10, 20, 800, 16'h1D3B);
        sweep(4090, 10, 800, 16'h5A5A);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule